// File: doc/BRIEF.md
# Serial Port Reset and Frame-Sync Timing Generator

This block derives the bit clock and the frame-sync pulse of a serial codec port from the master clock. It also sequences the two ways the port can be reset. An active-low reset pin and a one-cycle software request both raise an internal clear. The control-register bank uses that clear, and so does this block itself.

After every reset the port runs at a slow default timing so that a slow host can reach it. The bit clock is the master clock divided by 8. A frame lasts 2048 master cycles. A 2-bit rate code, written with a strobe, later shortens the frame. The new length never cuts a running frame short: it takes effect at the next frame boundary. The frame-sync pulse is one bit-clock period wide and appears only while the serial-enable input is high. The frame counter keeps running when serial-enable is low.

Top module: `port_timing_gen`

## Requirements
- R1: While `rstPinN` is low, `regClear` is 1 and `sclk` and `frameSync` are 0. After the pin goes high, `regClear` stays 1 for 4 more rising clock edges and reads 0 after the 4th.
- R2: A `swResetReq` sampled high at a rising edge makes `regClear` read 1 after that edge and the next 3 edges, and 0 after the 4th edge.
- R3: Once `regClear` has dropped, `sclk` has a period of 8 master cycles. It reads 0 for the first 4 cycles after the release edge and 1 for the next 4, and this pattern repeats.
- R4: With `serialEn` high, the first rising edge of `frameSync` is seen 2048 clock edges after the edge at which `regClear` dropped. No pulse comes before that.
- R5: Until a rate code is accepted, consecutive `frameSync` rises are 2048 master cycles apart.
- R6: An accepted rate code sets the frame length to 2048 >> code: code 0 gives 2048, code 1 gives 1024, code 2 gives 512 and code 3 gives 256 master cycles.
- R7: A `rateWrite` sampled inside a frame leaves that frame at its old length, and the new length starts at the next boundary. A write sampled on the boundary edge itself applies to the frame that starts at that edge.
- R8: Each `frameSync` pulse is high for exactly 8 master cycles, and it rises while `sclk` is 0.
- R9: While `serialEn` is low, `frameSync` stays 0 and frame timing continues. After `serialEn` is raised mid-frame, the next pulse falls on the unchanged frame grid.
- R10: Any reset returns the frame length to 2048 and discards any staged rate code. A `rateWrite` sampled while `regClear` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstPinN | input | 1 | Active-low hardware reset, asynchronous assert |
| swResetReq | input | 1 | Software reset request, sampled at the clock edge |
| serialEn | input | 1 | Enables the frame-sync output |
| rateSel | input | 2 | Frame-rate code |
| rateWrite | input | 1 | Strobe that accepts `rateSel` |
| sclk | output | 1 | Serial bit clock, master clock divided by 8 |
| frameSync | output | 1 | Frame-sync pulse, one bit-clock period wide |
| regClear | output | 1 | Clear held to the control-register bank |

## Verification
The delicate coincidence is a rate write on the same master-clock edge at which a frame ends. There the staging logic and the frame wrap act together.

The bench times the strobe so that it is sampled exactly on a boundary edge. The scoreboard then expects the next pulse one new period later, not one old period later. A second coincidence puts a rate write inside the reset window. It is judged by the pulses that follow keeping the 2048-cycle default spacing.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int RATE_W = 2;

  // Strobes and state handed from control to datapath
  typedef struct packed {
    logic              clear;
    logic              started;
    logic [RATE_W-1:0] shift;
  } ptgStrobe_t;
endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              swResetReq,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              rateWrite,
  input  logic              frameEnd,
  output ptgStrobe_t        strb,
  output logic              regClear
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0]  rstCnt;
  logic              inReset;
  logic [RATE_W-1:0] pendShift;
  logic              pendValid;
  logic [RATE_W-1:0] activeShift;
  logic              started;

  // Reset stretcher: pin or software request reloads the count
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      rstCnt <= CNT_W'(RST_LEN);
    end else if (swResetReq) begin
      rstCnt <= CNT_W'(RST_LEN);
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - CNT_W'(1);
    end
  end

  assign inReset  = (rstCnt != '0);
  assign regClear = inReset;

  // Rate staging: a code waits for the frame boundary
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      pendShift   <= '0;
      pendValid   <= 1'b0;
      activeShift <= '0;
      started     <= 1'b0;
    end else if (inReset) begin
      pendShift   <= '0;
      pendValid   <= 1'b0;
      activeShift <= '0;
      started     <= 1'b0;
    end else if (frameEnd) begin
      started <= 1'b1;
      if (rateWrite) begin
        activeShift <= rateSel;
        pendValid   <= 1'b0;
      end else if (pendValid) begin
        activeShift <= pendShift;
        pendValid   <= 1'b0;
      end
    end else if (rateWrite) begin
      pendShift <= rateSel;
      pendValid <= 1'b1;
    end
  end

  always_comb begin
    strb.clear   = inReset;
    strb.started = started;
    strb.shift   = activeShift;
  end

  // R2
  swreset_hold_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    swResetReq |=> regClear);

  // R10
  reset_rate_clear_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    inReset |=> (activeShift == '0) && !pendValid && !started);

  // R7
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    (!frameEnd && !inReset) |=> $stable(activeShift));
endmodule

// File: rtl/ptg_dpath.sv
module ptg_dpath
  import ptg_pkg::*;
#(
  parameter int BASE_DIV = 2048,
  parameter int SCLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rstPinN,
  input  logic       serialEn,
  input  ptgStrobe_t strb,
  output logic       frameEnd,
  output logic       sclk,
  output logic       frameSync
);
  localparam int FRAME_W = $clog2(BASE_DIV);
  localparam int SCLK_W  = $clog2(SCLK_DIV);

  logic [FRAME_W-1:0] frameCnt;
  logic [FRAME_W-1:0] lastCount;
  logic [SCLK_W-1:0]  sclkCnt;

  assign lastCount = FRAME_W'((BASE_DIV >> strb.shift) - 1);
  assign frameEnd  = (frameCnt == lastCount);

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      frameCnt <= '0;
    end else if (strb.clear || frameEnd) begin
      frameCnt <= '0;
    end else begin
      frameCnt <= frameCnt + FRAME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      sclkCnt <= '0;
    end else if (strb.clear || sclkCnt == SCLK_W'(SCLK_DIV - 1)) begin
      sclkCnt <= '0;
    end else begin
      sclkCnt <= sclkCnt + SCLK_W'(1);
    end
  end

  assign sclk      = (sclkCnt >= SCLK_W'(SCLK_DIV / 2));
  assign frameSync = serialEn && strb.started && (frameCnt < FRAME_W'(SCLK_DIV));

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    (frameEnd && !strb.clear) |=> (frameCnt == '0));

  // R3
  sclk_wrap_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    (!strb.clear && sclkCnt == SCLK_W'(SCLK_DIV - 1)) |=> (sclkCnt == '0));

  // R8
  fsync_phase_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(frameSync) |-> !sclk);
endmodule

// File: rtl/port_timing_gen.sv
module port_timing_gen
  import ptg_pkg::*;
#(
  parameter int BASE_DIV = 2048,
  parameter int SCLK_DIV = 8,
  parameter int RST_LEN  = 4
) (
  input  logic       mclk,
  input  logic       rstPinN,
  input  logic       swResetReq,
  input  logic       serialEn,
  input  logic [1:0] rateSel,
  input  logic       rateWrite,
  output logic       sclk,
  output logic       frameSync,
  output logic       regClear
);
  ptgStrobe_t strb;
  logic       frameEnd;

  ptg_ctrl #(.RST_LEN(RST_LEN)) u_ctrl (
    .clk        (mclk),
    .rstPinN    (rstPinN),
    .swResetReq (swResetReq),
    .rateSel    (rateSel),
    .rateWrite  (rateWrite),
    .frameEnd   (frameEnd),
    .strb       (strb),
    .regClear   (regClear)
  );

  ptg_dpath #(.BASE_DIV(BASE_DIV), .SCLK_DIV(SCLK_DIV)) u_dpath (
    .clk       (mclk),
    .rstPinN   (rstPinN),
    .serialEn  (serialEn),
    .strb      (strb),
    .frameEnd  (frameEnd),
    .sclk      (sclk),
    .frameSync (frameSync)
  );
endmodule

// File: tb/port_timing_gen_bench.sv
module port_timing_gen_bench;
  localparam int BASE = 2048;

  logic       clk = 1'b0;
  logic       rstPinN, swResetReq, serialEn, rateWrite;
  logic [1:0] rateSel;
  logic       sclk, frameSync, regClear;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int lastB, curP, w, s;
  int expCyc[$];
  string expTag[$];
  logic prevFs = 1'b0;
  int hiCnt = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  port_timing_gen u_port_timing_gen (
    .mclk(clk), .rstPinN(rstPinN), .swResetReq(swResetReq), .serialEn(serialEn),
    .rateSel(rateSel), .rateWrite(rateWrite), .sclk(sclk), .frameSync(frameSync),
    .regClear(regClear)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic pushExp(input int c, input string tag);
    expCyc.push_back(c);
    expTag.push_back(tag);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic writeRate(input int at, input logic [1:0] code);
    waitUntil(at - 1);
    rateSel   = code;
    rateWrite = 1'b1;
    @(negedge clk);
    rateWrite = 1'b0;
  endtask

  task automatic waitDrain();
    while (expCyc.size() != 0) begin
      @(negedge clk);
      if (expCyc.size() != 0 && cyc > expCyc[0] + 2) begin
        check(1'b0, expTag[0], cyc, expCyc[0], "frame-sync pulse missing");
        void'(expCyc.pop_front());
        void'(expTag.pop_front());
      end
    end
  endtask

  // Monitor: pops expected rise cycles and checks pulse shape
  always @(negedge clk) begin
    if (rstPinN === 1'b1) begin
      if (frameSync && !prevFs) begin
        hiCnt = 1;
        check(sclk == 1'b0, "R8", int'(sclk), 0, "sclk level at frame-sync rise");
        if (expCyc.size() == 0) begin
          check(1'b0, "R9", cyc, -1, "unexpected frame-sync rise");
        end else begin
          check(cyc == expCyc[0], expTag[0], cyc, expCyc[0], "frame-sync rise cycle");
          void'(expCyc.pop_front());
          void'(expTag.pop_front());
        end
      end else if (frameSync) begin
        hiCnt++;
      end else if (prevFs) begin
        check(hiCnt == 8, "R8", hiCnt, 8, "frame-sync width");
      end
    end
    prevFs = frameSync;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0, "run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstPinN = 1'b0; swResetReq = 1'b0; serialEn = 1'b1; rateSel = 2'd0; rateWrite = 1'b0;
    repeat (3) @(negedge clk);
    // R1: held by pin
    check(regClear == 1'b1, "R1", int'(regClear), 1, "regClear with pin low");
    check(sclk == 1'b0, "R1", int'(sclk), 0, "sclk with pin low");
    check(frameSync == 1'b0, "R1", int'(frameSync), 0, "frameSync with pin low");
    rstPinN = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(regClear == (k < 4), "R1", int'(regClear), int'(k < 4), "regClear after pin release");
    end
    lastB = cyc;
    curP  = BASE;
    pushExp(lastB + curP, "R4");
    pushExp(lastB + 2 * curP, "R5");
    lastB += 2 * curP;
    // R3: bit-clock phase after release
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      check(sclk == ((n % 8) >= 4), "R3", int'(sclk), int'((n % 8) >= 4), "sclk phase");
    end
    waitDrain();

    // R7: mid-frame write of code 2 waits for the boundary
    w = lastB + 100;
    pushExp(lastB + curP, "R7");
    lastB += curP;
    writeRate(w, 2'd2);
    curP = 512;
    pushExp(lastB + curP, "R6");
    pushExp(lastB + 2 * curP, "R6");
    lastB += 2 * curP;
    waitDrain();

    // R7: code 3 written on the boundary edge itself
    pushExp(lastB + curP, "R7");
    lastB += curP;
    writeRate(lastB, 2'd3);
    curP = 256;
    pushExp(lastB + curP, "R7");
    pushExp(lastB + 2 * curP, "R6");
    lastB += 2 * curP;
    waitDrain();

    // R6: code 1
    w = lastB + 20;
    pushExp(lastB + curP, "R6");
    lastB += curP;
    writeRate(w, 2'd1);
    curP = 1024;
    pushExp(lastB + curP, "R6");
    pushExp(lastB + 2 * curP, "R6");
    lastB += 2 * curP;
    waitDrain();

    // R6: code 0 back to the longest frame
    w = lastB + 300;
    pushExp(lastB + curP, "R6");
    lastB += curP;
    writeRate(w, 2'd0);
    curP = 2048;
    pushExp(lastB + curP, "R6");
    lastB += curP;
    waitDrain();

    // R9: serial enable low suppresses pulses, grid kept
    waitUntil(lastB + 50);
    serialEn = 1'b0;
    waitUntil(lastB + curP + 2);
    check(frameSync == 1'b0, "R9", int'(frameSync), 0, "frameSync while disabled");
    waitUntil(lastB + 2 * curP + 100);
    serialEn = 1'b1;
    lastB += 2 * curP;
    pushExp(lastB + curP, "R9");
    lastB += curP;
    waitDrain();

    // R2 and R10: staged code 3, then software reset, write during reset
    writeRate(lastB + 200, 2'd3);
    s = lastB + 300;
    waitUntil(s - 1);
    swResetReq = 1'b1;
    @(negedge clk);
    swResetReq = 1'b0;
    check(regClear == 1'b1, "R2", int'(regClear), 1, "regClear after request edge");
    rateSel   = 2'd1;
    rateWrite = 1'b1;
    @(negedge clk);
    rateWrite = 1'b0;
    check(regClear == 1'b1, "R2", int'(regClear), 1, "regClear 2nd cycle");
    check(frameSync == 1'b0, "R2", int'(frameSync), 0, "frameSync during reset");
    @(negedge clk);
    check(regClear == 1'b1, "R2", int'(regClear), 1, "regClear 3rd cycle");
    @(negedge clk);
    check(regClear == 1'b1, "R2", int'(regClear), 1, "regClear 4th cycle");
    @(negedge clk);
    check(regClear == 1'b0, "R2", int'(regClear), 0, "regClear released");
    lastB = cyc;
    curP  = BASE;
    pushExp(lastB + curP, "R10");
    pushExp(lastB + 2 * curP, "R10");
    waitDrain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule